// File: doc/BRIEF.md
# Isochronous SYT Timestamp Generator

This block produces the 16-bit presentation timestamp that a transmitter puts into the header of each outgoing isochronous audio packet. Time is measured in ticks of a 24.576 MHz clock, and one bus cycle of 125 µs holds 3072 ticks. A start pulse arms the generator for one sample-rate family and one buffering mode. After that, each per-cycle strobe moves a running event offset forward by one cycle.

If a sampling event falls inside the current cycle, the block adds a fixed transfer delay to the event's offset within the cycle. It then splits the result into a whole number of cycles and a remainder in ticks, and packs both into the timestamp: the low four bits of the target cycle count sit above a 12-bit tick field. If no event falls in the cycle, the block outputs the no-info code 0xFFFF. For the 44.1 kHz family, the increment between events alternates between 1386 and 1387 ticks. A 147-step phase counter reproduces the exact rounded sequence, so the long-run rate is exact with no fractional accumulator.

The output is registered. It appears one clock after the strobe, together with a one-clock valid pulse.

Top module: `syt_timestamp_gen`

## Requirements
- R1: While reset is asserted and after it is released, `syt_o` reads 0xFFFF and `syt_valid_o` reads 0 until the first accepted strobe.
- R2: A strobe with no start in the same clock makes `syt_valid_o` high for exactly the next clock, and `syt_o` carries the new value in that clock. `syt_o` keeps its value in every clock that follows no accepted strobe.
- R3: A start pulse loads the last offset with 3072, the 44.1 kHz-family phase with 67, and the rate family. A strobe in the same clock as a start is dropped: no valid pulse follows it and no state advances.
- R4: On each accepted strobe, the new offset is computed from the last offset L. If L < 3072, the new offset is L + increment. Otherwise it is L − 3072. If the new offset is 3072 or more, the output is 0xFFFF. A valid timestamp never equals 0xFFFF, so two no-info outputs never occur on consecutive strobes.
- R5: In the 48 kHz family the increment is 1024. After a start, the strobes give three timestamps and then one 0xFFFF, repeating.
- R6: In the 32 kHz family the increment is 3072. After a start, timestamps and 0xFFFF alternate, beginning with a timestamp.
- R7: In the 44.1 kHz family the increment is 1387 when the phase equals 146, or when phase mod 13 is nonzero and divisible by 4. Otherwise it is 1386. The phase advances by one, wrapping from 146 to 0, only on strobes where the last offset was below 3072.
- R8: With d the new offset plus the delay, and the cycle count n = seconds·8000 + cycle (seconds in `cycle_time_i[15:13]`, cycle in `[12:0]`), the timestamp is ((n + d div 3072) mod 16)·4096 + (d mod 3072).
- R9: In non-blocking mode the delay is 8704 ticks (0x2E00 minus one cycle).
- R10: In blocking mode the delay gains 6144 ticks for the 32 kHz family, 4458 for the 44.1 kHz family and 4096 for the 48 kHz family.
- R11: The rate code and the blocking flag are sampled only at start. Changing them while running has no effect on the output.
- R12: Rate codes: 0 = 32 kHz; 1, 3, 5 = 44.1, 88.2, 176.4 kHz; 2, 4, 6 = 48, 96, 192 kHz; code 7 behaves as the 48 kHz family.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| start_i | input | 1 | One-clock pulse: arm the generator, sample rate and mode |
| rate_i | input | 3 | Sample-rate code (see R12) |
| blocking_i | input | 1 | Blocking transmission mode, adds the per-family extra delay |
| cycle_strobe_i | input | 1 | One-clock pulse per bus cycle |
| cycle_time_i | input | 16 | Seconds [15:13] and cycle [12:0] of the current bus cycle |
| syt_o | output | 16 | Timestamp, or 0xFFFF when no event falls in the cycle |
| syt_valid_o | output | 1 | High for one clock, one clock after an accepted strobe |

## Verification
A corrupted last-offset register shifts the tick field on the very next strobe. It also moves the place of the 0xFFFF gaps within the following few strobes. A 44.1 kHz phase that is off by one step can stay hidden for a dozen or more strobes, until the 1387-tick step lands one event early or late. Long comparison runs that cross the phase wrap catch it. A wrong quotient or delay constant changes the upper nibble or the tick field on the first event after a start.

// File: rtl/syt_pkg.sv
package syt_pkg;

  localparam int RATE_CODE_W = 3;

  typedef enum logic [1:0] {
    FAM_32K = 2'd0,
    FAM_44K = 2'd1,
    FAM_48K = 2'd2
  } rate_fam_e;

  function automatic rate_fam_e fam_of_code(input logic [RATE_CODE_W-1:0] code);
    rate_fam_e f;
    case (code)
      3'd0:                f = FAM_32K;
      3'd1, 3'd3, 3'd5:    f = FAM_44K;
      default:             f = FAM_48K;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/syt_cycle_count.sv
module syt_cycle_count #(
  parameter int SEC_W       = 3,
  parameter int CYC_W       = 13,
  parameter int CYC_PER_SEC = 8000,
  parameter int CNT_W       = 16
) (
  input  logic [SEC_W+CYC_W-1:0] time_i,
  output logic [CNT_W-1:0]       count_o
);

  logic [SEC_W-1:0] sec;
  logic [CYC_W-1:0] cyc;

  always_comb begin
    sec     = time_i[SEC_W+CYC_W-1:CYC_W];
    cyc     = time_i[CYC_W-1:0];
    count_o = CNT_W'(sec) * CNT_W'(CYC_PER_SEC) + CNT_W'(cyc);
  end

endmodule

// File: rtl/syt_offset_step.sv
module syt_offset_step
  import syt_pkg::*;
#(
  parameter int TICKS       = 3072,
  parameter int INC_BASE    = 1386,
  parameter int PHASE_N     = 147,
  parameter int PHASE_MOD   = 13,
  parameter int PHASE_START = 67,
  parameter int OFF_W       = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  rate_fam_e        fam_i,
  input  logic             step_i,
  output rate_fam_e        fam_o,
  output logic [OFF_W-1:0] new_off_o,
  output logic             event_o
);

  localparam int PH_W      = $clog2(PHASE_N);
  localparam int SUB_W     = $clog2(PHASE_MOD);
  localparam int SUB_START = PHASE_START % PHASE_MOD;
  localparam int INC_32K   = TICKS;
  localparam int INC_48K   = TICKS / 3;

  logic [OFF_W-1:0] last_q, last_d;
  logic [PH_W-1:0]  phase_q, phase_d;
  logic [SUB_W-1:0] sub_q, sub_d;
  rate_fam_e        fam_q, fam_d;

  logic             below;
  logic             bump;
  logic [OFF_W-1:0] inc;

  // next-state
  always_comb begin
    bump = ((sub_q != '0) && (sub_q[1:0] == 2'b00)) ||
           (phase_q == PH_W'(PHASE_N - 1));
    case (fam_q)
      FAM_32K: inc = OFF_W'(INC_32K);
      FAM_44K: inc = OFF_W'(INC_BASE) + OFF_W'(bump);
      default: inc = OFF_W'(INC_48K);
    endcase
    below     = last_q < OFF_W'(TICKS);
    new_off_o = below ? (last_q + inc) : (last_q - OFF_W'(TICKS));
    event_o   = new_off_o < OFF_W'(TICKS);

    last_d  = last_q;
    phase_d = phase_q;
    sub_d   = sub_q;
    fam_d   = fam_q;
    if (start_i) begin
      last_d  = OFF_W'(TICKS);
      phase_d = PH_W'(PHASE_START);
      sub_d   = SUB_W'(SUB_START);
      fam_d   = fam_i;
    end else if (step_i) begin
      last_d = new_off_o;
      if (below && (fam_q == FAM_44K)) begin
        if (phase_q == PH_W'(PHASE_N - 1)) begin
          phase_d = '0;
          sub_d   = '0;
        end else begin
          phase_d = phase_q + 1'b1;
          sub_d   = (sub_q == SUB_W'(PHASE_MOD - 1)) ? '0 : sub_q + 1'b1;
        end
      end
    end
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q  <= OFF_W'(TICKS);
      phase_q <= '0;
      sub_q   <= '0;
      fam_q   <= FAM_48K;
    end else if (start_i || step_i) begin
      last_q  <= last_d;
      phase_q <= phase_d;
      sub_q   <= sub_d;
      fam_q   <= fam_d;
    end
  end

  assign fam_o = fam_q;

  // R4: the offset never runs past one cycle plus the largest increment
  p_last_bounded_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_q <= OFF_W'(TICKS + INC_BASE + 1));

  // R7: phase stays inside its 147-step range
  p_phase_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q < PH_W'(PHASE_N));

  // R7: the mod-13 side counter agrees with the phase
  p_sub_tracks_phase_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(phase_q) % PHASE_MOD) == 32'(sub_q));

endmodule

// File: rtl/syt_delay_sel.sv
module syt_delay_sel
  import syt_pkg::*;
#(
  parameter int TICKS      = 3072,
  parameter int XFER_DELAY = 11776,
  parameter int EXTRA_32K  = 6144,
  parameter int EXTRA_44K  = 4458,
  parameter int EXTRA_48K  = 4096,
  parameter int OFF_W      = 15
) (
  input  rate_fam_e        fam_i,
  input  logic             blocking_i,
  output logic [OFF_W-1:0] delay_o
);

  localparam int BASE = XFER_DELAY - TICKS;

  logic [OFF_W-1:0] extra;

  always_comb begin
    case (fam_i)
      FAM_32K: extra = OFF_W'(EXTRA_32K);
      FAM_44K: extra = OFF_W'(EXTRA_44K);
      default: extra = OFF_W'(EXTRA_48K);
    endcase
    delay_o = OFF_W'(BASE) + (blocking_i ? extra : '0);
  end

endmodule

// File: rtl/syt_stamp.sv
module syt_stamp #(
  parameter int TICKS   = 3072,
  parameter int OFF_W   = 15,
  parameter int CNT_W   = 16,
  parameter int SYT_W   = 16,
  parameter int MAX_OFF = 17919
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [SYT_W-1:0] stamp_o
);

  localparam int LOW_W = $clog2(TICKS);
  localparam int HI_W  = SYT_W - LOW_W;
  localparam int MAXQ  = MAX_OFF / TICKS;
  localparam int QW    = $clog2(MAXQ + 1);

  logic [MAXQ-1:0]  ge;
  logic [QW-1:0]    q;
  logic [OFF_W-1:0] rem;
  logic [CNT_W-1:0] sum;
  logic             unused_bits;

  // thermometer of whole cycles contained in the offset
  for (genvar k = 1; k <= MAXQ; k++) begin : g_cmp
    assign ge[k-1] = off_i >= OFF_W'(k * TICKS);
  end

  always_comb begin
    q       = QW'($countones(ge));
    rem     = off_i - OFF_W'(32'(q) * TICKS);
    sum     = count_i + CNT_W'(q);
    stamp_o = {sum[HI_W-1:0], rem[LOW_W-1:0]};
  end

  assign unused_bits = ^{sum[CNT_W-1:HI_W], rem[OFF_W-1:LOW_W]};

endmodule

// File: rtl/syt_timestamp_gen.sv
module syt_timestamp_gen
  import syt_pkg::*;
#(
  parameter int TICKS       = 3072,
  parameter int XFER_DELAY  = 11776,
  parameter int CYC_PER_SEC = 8000,
  parameter int SEC_W       = 3,
  parameter int CYC_W       = 13,
  parameter int SYT_W       = 16,
  parameter int INC_BASE    = 1386,
  parameter int PHASE_N     = 147,
  parameter int PHASE_MOD   = 13,
  parameter int PHASE_START = 67,
  parameter int EXTRA_32K   = 6144,
  parameter int EXTRA_44K   = 4458,
  parameter int EXTRA_48K   = 4096
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [RATE_CODE_W-1:0] rate_i,
  input  logic                   blocking_i,
  input  logic                   cycle_strobe_i,
  input  logic [SEC_W+CYC_W-1:0] cycle_time_i,
  output logic [SYT_W-1:0]       syt_o,
  output logic                   syt_valid_o
);

  localparam int TIME_W    = SEC_W + CYC_W;
  localparam int MAX_CNT   = ((1 << SEC_W) - 1) * CYC_PER_SEC + (1 << CYC_W) - 1;
  localparam int CNT_W     = $clog2(MAX_CNT + 1);
  localparam int MAX_EX_A  = (EXTRA_32K > EXTRA_44K) ? EXTRA_32K : EXTRA_44K;
  localparam int MAX_EXTRA = (MAX_EX_A > EXTRA_48K) ? MAX_EX_A : EXTRA_48K;
  localparam int MAX_OFF   = XFER_DELAY - 1 + MAX_EXTRA;
  localparam int OFF_W     = $clog2(MAX_OFF + 1);
  localparam logic [SYT_W-1:0] NO_INFO = {SYT_W{1'b1}};

  logic             step;
  rate_fam_e        fam;
  logic [OFF_W-1:0] new_off;
  logic             ev;
  logic [OFF_W-1:0] delay;
  logic [OFF_W-1:0] off_total;
  logic [CNT_W-1:0] count;
  logic [SYT_W-1:0] stamp;

  logic             blk_q, blk_d;
  logic [SYT_W-1:0] syt_q, syt_d;
  logic             valid_q, valid_d;

  assign step = cycle_strobe_i & ~start_i;

  syt_cycle_count #(
    .SEC_W(SEC_W), .CYC_W(CYC_W), .CYC_PER_SEC(CYC_PER_SEC), .CNT_W(CNT_W)
  ) u_count (
    .time_i (cycle_time_i[TIME_W-1:0]),
    .count_o(count)
  );

  syt_offset_step #(
    .TICKS(TICKS), .INC_BASE(INC_BASE), .PHASE_N(PHASE_N),
    .PHASE_MOD(PHASE_MOD), .PHASE_START(PHASE_START), .OFF_W(OFF_W)
  ) u_offset (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .fam_i    (fam_of_code(rate_i)),
    .step_i   (step),
    .fam_o    (fam),
    .new_off_o(new_off),
    .event_o  (ev)
  );

  syt_delay_sel #(
    .TICKS(TICKS), .XFER_DELAY(XFER_DELAY), .EXTRA_32K(EXTRA_32K),
    .EXTRA_44K(EXTRA_44K), .EXTRA_48K(EXTRA_48K), .OFF_W(OFF_W)
  ) u_delay (
    .fam_i     (fam),
    .blocking_i(blk_q),
    .delay_o   (delay)
  );

  assign off_total = new_off + delay;

  syt_stamp #(
    .TICKS(TICKS), .OFF_W(OFF_W), .CNT_W(CNT_W), .SYT_W(SYT_W), .MAX_OFF(MAX_OFF)
  ) u_stamp (
    .count_i(count),
    .off_i  (off_total),
    .stamp_o(stamp)
  );

  // next-state
  always_comb begin
    blk_d   = start_i ? blocking_i : blk_q;
    valid_d = step;
    syt_d   = syt_q;
    if (step) begin
      syt_d = ev ? stamp : NO_INFO;
    end
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q   <= 1'b0;
      syt_q   <= NO_INFO;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (start_i) blk_q <= blk_d;
      if (step)    syt_q <= syt_d;
    end
  end

  assign syt_o       = syt_q;
  assign syt_valid_o = valid_q;

  // R2: valid pulse one clock after an accepted strobe
  p_valid_after_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_strobe_i && !start_i) |=> syt_valid_o);

  // R2: output held when no strobe was accepted
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cycle_strobe_i && !start_i) |=> (!syt_valid_o && $stable(syt_o)));

  // R3: a strobe coinciding with start is dropped
  p_start_drops_strobe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !syt_valid_o);

  // R4: no two no-info codes on back-to-back strobes
  p_noinfo_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (syt_valid_o && (syt_o == NO_INFO) && cycle_strobe_i && !start_i)
      |=> (syt_o != NO_INFO));

  // R8: the tick field of a real stamp stays inside one cycle
  p_low_field_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (syt_valid_o && (syt_o != NO_INFO)) |-> (32'(syt_o[$clog2(TICKS)-1:0]) < TICKS));

endmodule

// File: tb/test_syt_timestamp_gen.sv
module test_syt_timestamp_gen;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [2:0]  rate;
  logic        blocking;
  logic        strobe;
  logic [15:0] cycle_time;
  logic [15:0] syt;
  logic        valid;

  always #2 clk = ~clk;

  syt_timestamp_gen i_syt_timestamp_gen (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .start_i       (start),
    .rate_i        (rate),
    .blocking_i    (blocking),
    .cycle_strobe_i(strobe),
    .cycle_time_i  (cycle_time),
    .syt_o         (syt),
    .syt_valid_o   (valid)
  );

  int n_checks = 0;
  int n_errors = 0;
  int m_last, m_phase, m_fam, m_blk;
  int t_cnt;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int fam_of(input int code);
    if (code == 0) return 0;
    if (code == 1 || code == 3 || code == 5) return 1;
    return 2;
  endfunction

  function automatic int delay_of(input int fam, input int blk);
    int extra;
    extra = (fam == 0) ? 6144 : (fam == 1) ? 4458 : 4096;
    return 8704 + (blk != 0 ? extra : 0);
  endfunction

  task automatic model_step(input int cnt, output int exp);
    int inc, nw, d, p13;
    if (m_last < 3072) begin
      if (m_fam == 0) inc = 3072;
      else if (m_fam == 2) inc = 1024;
      else begin
        p13 = m_phase % 13;
        inc = 1386 + (((p13 != 0 && p13 % 4 == 0) || m_phase == 146) ? 1 : 0);
        m_phase = (m_phase + 1) % 147;
      end
      nw = m_last + inc;
    end else begin
      nw = m_last - 3072;
    end
    m_last = nw;
    if (nw < 3072) begin
      d = nw + delay_of(m_fam, m_blk);
      exp = (((cnt + d / 3072) % 16) * 4096) + (d % 3072);
    end else begin
      exp = 16'hFFFF;
    end
  endtask

  task automatic pulse_start(input int code, input int blk);
    @(negedge clk);
    start = 1'b1; rate = 3'(code); blocking = 1'(blk);
    @(negedge clk);
    start = 1'b0;
    m_last = 3072; m_phase = 67; m_fam = fam_of(code); m_blk = blk;
  endtask

  task automatic do_strobe(output int s, output int v);
    @(negedge clk);
    cycle_time = {3'(t_cnt / 8000), 13'(t_cnt % 8000)};
    strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
    s = int'(syt); v = int'(valid);
    t_cnt = (t_cnt + 1) % 64000;
  endtask

  task automatic run_compare(input int code, input int blk, input int n, input int cnt0,
                             input string req);
    int s, v, e;
    t_cnt = cnt0;
    pulse_start(code, blk);
    for (int i = 0; i < n; i++) begin
      model_step(t_cnt, e);
      do_strobe(s, v);
      check(req, "valid", v, 1);
      check(req, "syt", s, e);
    end
  endtask

  task automatic t_reset;
    check("R1", "syt after reset", int'(syt), 16'hFFFF);
    check("R1", "valid after reset", int'(valid), 0);
  endtask

  task automatic t_hand_48k;
    int s, v;
    t_cnt = 100;
    pulse_start(2, 0);
    do_strobe(s, v); check("R5 R8 R9", "48k first", s, 16'h6A00);
    do_strobe(s, v); check("R5", "48k second", s, 16'h8200);
    do_strobe(s, v); check("R5", "48k third", s, 16'h9600);
    do_strobe(s, v); check("R5 R4", "48k gap", s, 16'hFFFF);
  endtask

  task automatic t_hand_32k_blocking;
    int s, v;
    t_cnt = 5;
    pulse_start(0, 1);
    do_strobe(s, v); check("R10 R6", "32k blk first", s, 16'h9A00);
    do_strobe(s, v); check("R6", "32k gap", s, 16'hFFFF);
    do_strobe(s, v); check("R6 R10", "32k blk third", s, 16'hBA00);
  endtask

  task automatic t_hand_44k;
    int s, v;
    t_cnt = 16000;
    pulse_start(1, 0);
    for (int i = 0; i < 3; i++) do_strobe(s, v);
    do_strobe(s, v); check("R7", "44k gap after 1387 step", s, 16'hFFFF);
    do_strobe(s, v); check("R7 R8", "44k fifth", s, 16'h723F);
  endtask

  task automatic t_hold;
    int s0;
    s0 = int'(syt);
    repeat (5) @(negedge clk);
    check("R2", "valid idle", int'(valid), 0);
    check("R2", "syt held", int'(syt), s0);
  endtask

  task automatic t_start_strobe_same;
    int s, v, e;
    t_cnt = 200;
    pulse_start(2, 0);
    @(negedge clk);
    start = 1'b1; strobe = 1'b1; rate = 3'd2; blocking = 1'b0;
    cycle_time = 16'd200;
    @(negedge clk);
    start = 1'b0; strobe = 1'b0;
    check("R3", "strobe with start gives no valid", int'(valid), 0);
    model_step(t_cnt, e);
    do_strobe(s, v);
    check("R3", "state not advanced by dropped strobe", s, e);
  endtask

  task automatic t_latch;
    int s, v, e;
    t_cnt = 300;
    pulse_start(2, 0);
    @(negedge clk);
    rate = 3'd0; blocking = 1'b1;
    for (int i = 0; i < 8; i++) begin
      model_step(t_cnt, e);
      do_strobe(s, v);
      check("R11", "inputs ignored while running", s, e);
    end
  endtask

  task automatic t_code7;
    int s, v;
    t_cnt = 100;
    pulse_start(7, 0);
    do_strobe(s, v); check("R12", "code 7 first", s, 16'h6A00);
    do_strobe(s, v); check("R12", "code 7 second", s, 16'h8200);
  endtask

  initial begin
    #(200000 * 4);
    n_errors++;
    $display("FAIL watchdog (all requirements): actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; rate = '0; blocking = 1'b0;
    strobe = 1'b0; cycle_time = '0; t_cnt = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_hand_48k();
    t_hold();
    t_hand_32k_blocking();
    t_hand_44k();
    t_start_strobe_same();
    t_latch();
    t_code7();
    for (int code = 0; code < 8; code++) begin
      for (int blk = 0; blk < 2; blk++) begin
        run_compare(code, blk, 40, 63980, "R4 R8 R10 R12");
      end
    end
    run_compare(1, 0, 320, 7990, "R7");
    run_compare(3, 1, 320, 100, "R7 R10");
    run_compare(5, 0, 200, 40000, "R7 R12");
    run_compare(4, 0, 60, 500, "R5");
    run_compare(0, 0, 60, 500, "R6");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule